// File: doc/BRIEF.md
# Quad-Set Packed Coefficient Store

This block keeps the coefficient tables of four FIR filters in a single 18 Kbit storage array. The array is organised as 512 words of 36 bits. Each word is split into two 18-bit lanes, and the array is split into two halves by the top address bit. Each half has its own read port. One read port therefore serves two filters at once. The two filters on a port always step through their tables with the same index, and each one receives its own lane of the word that index selects.

Filters 0 and 1 are read through port A, which reaches the lower half of the array. Filters 2 and 3 are read through port B, which reaches the upper half. Inside each half only the first 64 words are addressed, and the bits between the half-select bit and the 6-bit index are held at zero. A separate load port writes one 18-bit coefficient per cycle. It takes a filter number and an index, and it updates only the lane that belongs to that filter. The filter datapaths that use these coefficients sit outside this block.

Top module: `coef_quad_store`

## Requirements
- R1: While `rstN` is low, all four coefficient outputs read zero.
- R2: An index presented on `rdIdxA` or `rdIdxB` before a rising clock edge produces its coefficients after that edge, one cycle of latency. The outputs do not change before that edge.
- R3: Port A puts word bits [17:0] on `coefF0` and bits [35:18] on `coefF1`, both from the one word chosen by `rdIdxA`. Port B does the same for `coefF2` and `coefF3` using `rdIdxB`.
- R4: Port A reads only word address {0, 00, index} and port B reads only word address {1, 00, index}. A write for filter 0 or 1 never changes what port B returns, and a write for filter 2 or 3 never changes what port A returns.
- R5: A write with `wrSel` = f stores `wrData` at `wrIdx` for filter f. Bit 1 of `wrSel` picks the half and bit 0 picks the lane (0 for bits [17:0], 1 for bits [35:18]). The other lane of the same word is left unchanged.
- R6: If a read and a write hit the same word in the same cycle, the read returns the data held before the write. The new value is returned from the next cycle on.
- R7: Ports A and B read different indices in the same cycle without affecting each other.
- R8: When `wrEn` is low, `wrSel`, `wrIdx` and `wrData` have no effect on the stored contents.
- R9: While a port's index is held and no write occurs, that port's outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output registers |
| wrEn | input | 1 | Load strobe |
| wrSel | input | 2 | Filter number 0 to 3 for the load |
| wrIdx | input | 6 | Coefficient index for the load |
| wrData | input | 18 | Coefficient value to load |
| rdIdxA | input | 6 | Shared index for filters 0 and 1 |
| rdIdxB | input | 6 | Shared index for filters 2 and 3 |
| coefF0 | output | 18 | Filter 0 coefficient (port A, low lane) |
| coefF1 | output | 18 | Filter 1 coefficient (port A, high lane) |
| coefF2 | output | 18 | Filter 2 coefficient (port B, low lane) |
| coefF3 | output | 18 | Filter 3 coefficient (port B, high lane) |

## Verification
Read data is due one rising edge after the index is applied. A load becomes visible to a read issued on the edge after the write edge, so a read on the write edge itself still sees the old word. The bench changes inputs on falling edges and checks the outputs on the next falling edge, which puts exactly one rising edge between stimulus and result. For the latency check it also looks just after the index changes, to confirm the outputs have not yet moved. The read-first case checks both cycles: the old value first, then the new one.

// File: rtl/coef_quad_pkg.sv
package coef_quad_pkg;
  localparam int COEF_W     = 18;
  localparam int LANES      = 2;
  localparam int IDX_W      = 6;
  localparam int ADDR_W     = 9;
  localparam int WORD_W     = COEF_W * LANES;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int LANE_SEL_W = $clog2(LANES);
  localparam int FILT_W     = LANE_SEL_W + 1;
  localparam int PAD_W      = ADDR_W - 1 - IDX_W;

  typedef struct packed {
    logic [ADDR_W-1:0] wrAddr;
    logic [LANES-1:0]  laneWe;
    logic [ADDR_W-1:0] rdAddrA;
    logic [ADDR_W-1:0] rdAddrB;
  } bankStrobe_t;
endpackage

// File: rtl/coef_quad_ctrl.sv
module coef_quad_ctrl
  import coef_quad_pkg::*;
(
  input  logic              wrEn,
  input  logic [FILT_W-1:0] wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output bankStrobe_t       strobe
);
  localparam logic [PAD_W-1:0] PadZero = '0;

  // The top filter-number bit picks the half; the low bits pick the lane.
  always_comb begin
    strobe.wrAddr  = {wrSel[FILT_W-1], PadZero, wrIdx};
    strobe.rdAddrA = {1'b0, PadZero, rdIdxA};
    strobe.rdAddrB = {1'b1, PadZero, rdIdxB};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_laneDecode
    assign strobe.laneWe[l] = wrEn && (wrSel[LANE_SEL_W-1:0] == LANE_SEL_W'(l));
  end
endmodule

// File: rtl/coef_quad_array.sv
module coef_quad_array
  import coef_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [COEF_W-1:0] wrData,
  output logic [WORD_W-1:0] wordA,
  output logic [WORD_W-1:0] wordB
);
  // Each lane is its own column with its own write enable. Reads use
  // non-blocking updates, so a read on the write edge sees the old word.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [COEF_W-1:0] laneMem [DEPTH];
    logic [COEF_W-1:0] laneRdA, laneRdB;

    always_ff @(posedge clk) begin
      if (strobe.laneWe[l]) laneMem[strobe.wrAddr] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneRdA <= '0;
        laneRdB <= '0;
      end else begin
        laneRdA <= laneMem[strobe.rdAddrA];
        laneRdB <= laneMem[strobe.rdAddrB];
      end
    end

    assign wordA[l*COEF_W +: COEF_W] = laneRdA;
    assign wordB[l*COEF_W +: COEF_W] = laneRdB;
  end

  // Port A stays in the lower half and port B in the upper half, both
  // with the padding bits at zero.
  assert_half_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddrA[ADDR_W-1 -: PAD_W+1] == '0);
  assert_half_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAddrB[ADDR_W-1 -: PAD_W+1] == {1'b1, {PAD_W{1'b0}}});
  // A load touches at most one lane.
  assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.laneWe));
endmodule

// File: rtl/coef_quad_store.sv
module coef_quad_store
  import coef_quad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [COEF_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [COEF_W-1:0] coefF0,
  output logic [COEF_W-1:0] coefF1,
  output logic [COEF_W-1:0] coefF2,
  output logic [COEF_W-1:0] coefF3
);
  bankStrobe_t       strobe;
  logic [WORD_W-1:0] wordA, wordB;

  coef_quad_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrIdx  (wrIdx),
    .rdIdxA (rdIdxA),
    .rdIdxB (rdIdxB),
    .strobe (strobe)
  );

  coef_quad_array u_array (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .wordA  (wordA),
    .wordB  (wordB)
  );

  assign coefF0 = wordA[0 +: COEF_W];
  assign coefF1 = wordA[COEF_W +: COEF_W];
  assign coefF2 = wordB[0 +: COEF_W];
  assign coefF3 = wordB[COEF_W +: COEF_W];

  // Counts edges since reset so the hold checks only look back over
  // cycles that followed reset.
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  assert_hold_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2 && $past(rdIdxA) == $past(rdIdxA, 2) && !$past(wrEn, 2))
      |-> ($stable(coefF0) && $stable(coefF1)));
  assert_hold_b_R9: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2 && $past(rdIdxB) == $past(rdIdxB, 2) && !$past(wrEn, 2))
      |-> ($stable(coefF2) && $stable(coefF3)));
endmodule

// File: rtl/coef_quad_top.sv
module coef_quad_top (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [5:0]  wrIdx,
  input  logic [17:0] wrData,
  input  logic [5:0]  rdIdxA,
  input  logic [5:0]  rdIdxB,
  output logic [17:0] coefF0,
  output logic [17:0] coefF1,
  output logic [17:0] coefF2,
  output logic [17:0] coefF3
);
  coef_quad_store u_store (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .coefF0(coefF0), .coefF1(coefF1), .coefF2(coefF2), .coefF3(coefF3)
  );
endmodule

// File: tb/sim_coef_quad_store.sv
module sim_coef_quad_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [5:0]  wrIdx = '0;
  logic [17:0] wrData = '0;
  logic [5:0]  rdIdxA = '0;
  logic [5:0]  rdIdxB = '0;
  logic [17:0] coefF0, coefF1, coefF2, coefF3;

  int nChecks = 0;
  int nErrors = 0;
  logic [17:0] model [4][64];

  // Each entry holds {port A index, port B index}.
  localparam logic [11:0] VEC [0:15] = '{
    {6'd0, 6'd0}, {6'd63, 6'd63}, {6'd0, 6'd63}, {6'd63, 6'd0},
    {6'd1, 6'd2}, {6'd31, 6'd32}, {6'd32, 6'd31}, {6'd21, 6'd42},
    {6'd42, 6'd21}, {6'd10, 6'd10}, {6'd7, 6'd56}, {6'd56, 6'd7},
    {6'd15, 6'd48}, {6'd48, 6'd15}, {6'd33, 6'd33}, {6'd5, 6'd60}
  };

  always #10 clk = ~clk;

  coef_quad_store u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrIdx(wrIdx),
    .wrData(wrData), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .coefF0(coefF0), .coefF1(coefF1), .coefF2(coefF2), .coefF3(coefF3)
  );

  function automatic logic [17:0] pat(int f, int i);
    return 18'((f + 1) * 5000 + i * 61 + ((i ^ f) * 3));
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  // Entered and left on a falling edge.
  task automatic writeCoef(int f, int i, logic [17:0] d);
    wrEn = 1'b1; wrSel = 2'(f); wrIdx = 6'(i); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model[f][i] = d;
  endtask

  task automatic readPair(int ia, int ib, string tag);
    rdIdxA = 6'(ia); rdIdxB = 6'(ib);
    @(negedge clk);
    chk({tag, " F0"}, coefF0, model[0][ia]);
    chk({tag, " F1"}, coefF1, model[1][ia]);
    chk({tag, " F2"}, coefF2, model[2][ib]);
    chk({tag, " F3"}, coefF3, model[3][ib]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [17:0] oldF0, oldF3, heldA;
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk("R1 F0", coefF0, '0); chk("R1 F1", coefF1, '0);
    chk("R1 F2", coefF2, '0); chk("R1 F3", coefF3, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: load all four sets
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 64; i++)
        writeCoef(f, i, pat(f, i));

    // R3: table of index pairs
    for (int v = 0; v < 16; v++)
      readPair(int'(VEC[v][11:6]), int'(VEC[v][5:0]), "R3 table");

    // R7: sweep both ports at once in opposite directions
    for (int i = 0; i < 64; i++) readPair(i, 63 - i, "R7 sweep");

    // R2: no change before the edge, new data after it
    rdIdxA = 6'd4; rdIdxB = 6'd4;
    @(negedge clk);
    rdIdxA = 6'd40; rdIdxB = 6'd41;
    #2;
    chk("R2 before edge F0", coefF0, model[0][4]);
    chk("R2 before edge F2", coefF2, model[2][4]);
    @(negedge clk);
    chk("R2 after edge F1", coefF1, model[1][40]);
    chk("R2 after edge F3", coefF3, model[3][41]);

    // R6: read-first on the write edge, port A low lane and port B high lane
    rdIdxA = 6'd5; rdIdxB = 6'd9;
    @(negedge clk);
    oldF0 = model[0][5];
    oldF3 = model[3][9];
    wrEn = 1'b1; wrSel = 2'd0; wrIdx = 6'd5; wrData = 18'h2A5A5;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R6 old F0", coefF0, oldF0);
    chk("R5 other lane F1", coefF1, model[1][5]);
    model[0][5] = 18'h2A5A5;
    @(negedge clk);
    chk("R6 new F0", coefF0, model[0][5]);
    chk("R5 other lane F1 kept", coefF1, model[1][5]);
    wrEn = 1'b1; wrSel = 2'd3; wrIdx = 6'd9; wrData = 18'h15A5A;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R6 old F3", coefF3, oldF3);
    model[3][9] = 18'h15A5A;
    @(negedge clk);
    chk("R6 new F3", coefF3, model[3][9]);
    chk("R5 other lane F2 kept", coefF2, model[2][9]);

    // R4: a filter 1 load leaves port B alone at the same index
    rdIdxA = 6'd20; rdIdxB = 6'd20;
    writeCoef(1, 20, 18'h3FFFF);
    @(negedge clk);
    chk("R4 F1 updated", coefF1, 18'h3FFFF);
    chk("R4 F2 untouched", coefF2, model[2][20]);
    chk("R4 F3 untouched", coefF3, model[3][20]);
    writeCoef(2, 30, 18'h00001);
    readPair(30, 30, "R4 after filter2 load");

    // R8: load fields with wrEn low do nothing
    wrEn = 1'b0; wrSel = 2'd2; wrIdx = 6'd7; wrData = 18'h12345;
    @(negedge clk);
    wrSel = 2'd1; wrIdx = 6'd7; wrData = 18'h0BEEF;
    @(negedge clk);
    readPair(7, 7, "R8 ignored load");

    // R9: held index gives a steady output
    rdIdxA = 6'd50; rdIdxB = 6'd51;
    @(negedge clk);
    heldA = coefF0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 hold F0", coefF0, heldA);
      chk("R9 hold F3", coefF3, model[3][51]);
    end

    summary();
    $finish;
  end
endmodule